// File: doc/BRIEF.md
# Quadrature Encoder Electrical-Angle and Speed Unit

This block takes the two phase signals of an incremental shaft encoder and turns them into an electrical rotor angle and a speed estimate for a motor current loop. Each phase is first brought into the clock domain and then filtered. A new level is accepted only after it has stayed put for a software-chosen number of samples. Every accepted transition on exactly one phase is one step of the shaft, and the direction of that step follows the usual quadrature rule.

The angle is kept in fixed point with eight fractional bits. The number of encoder steps in one electrical revolution (line count times counted edges, divided by pole pairs) is generally not an integer. The wrap therefore subtracts or adds the exact fractional limit, so the residue carries over into the next revolution instead of being lost.

Speed comes from timing the gap between consecutive steps in clock ticks. A sequential divider turns that gap into `spd_scale / period`. The caller picks the scale so that the quotient is in the desired unit, for example RPM. If no step arrives before a programmable timeout, the speed is reported as zero.

Top module: `enc_angle_unit`

## Requirements
- R1: After reset, `elec_pos`, `dir_cw`, `period`, `period_vld`, `speed` and `speed_vld` are all zero.
- R2: Each phase passes a two-stage synchronizer and is then accepted at a new level only after `db_len` consecutive samples at that level (a `db_len` of 0 acts as 1). A shorter pulse changes no output.
- R3: An accepted transition on exactly one phase is one step. Its effect on `elec_pos`, `dir_cw` and `period` becomes visible `max(db_len,1)+3` clock cycles after the input pin changes, and not one cycle earlier.
- R4: The step is clockwise (`dir_cw`=1) when, on a phase-A transition, the new A differs from B, or when, on a phase-B transition, the new B equals A. Otherwise it is counter-clockwise. `dir_cw` holds the direction of the latest step.
- R5: `elec_pos` is unsigned fixed point with 8 fractional bits, so one step is 256. A clockwise step adds 256, and if the sum is at least `wrap_lim` it then subtracts `wrap_lim`.
- R6: A counter-clockwise step subtracts 256 when `elec_pos` is at least 256. Otherwise it sets `elec_pos` to `elec_pos + wrap_lim - 256`.
- R7: When both phases are accepted at a new level in the same cycle, the event is ignored: `elec_pos`, `dir_cw` and `period` keep their values and `period_vld` stays low.
- R8: On a step, `period` loads the number of clock cycles since the previous step and `period_vld` is high for one cycle, in the same cycle that `elec_pos` shows the step.
- R9: If `tmo_lim` cycles pass without a step, `speed` is forced to 0. The first step after reset or after such a timeout, or a step whose gap is `tmo_lim` or more, only restarts the measurement: `period_vld` stays low.
- R10: After each `period_vld`, `speed` becomes `floor(spd_scale / period)` with a one-cycle `speed_vld`, `SC_W` cycles later. A newer period restarts the division.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| db_len | input | DB_W | Consecutive samples needed to accept a new level |
| wrap_lim | input | POS_W | Steps per electrical revolution, 8 fractional bits; static outside reset |
| tmo_lim | input | PER_W | Cycles without a step after which speed reads zero |
| spd_scale | input | SC_W | Dividend of the speed quotient |
| elec_pos | output | POS_W | Electrical angle, 8 fractional bits |
| dir_cw | output | 1 | Direction of the latest step, 1 = clockwise |
| period | output | PER_W | Cycles between the last two steps |
| period_vld | output | 1 | One-cycle strobe when `period` loads |
| speed | output | SC_W | `spd_scale / period`, or 0 after a timeout |
| speed_vld | output | 1 | One-cycle strobe when `speed` loads a quotient |

## Verification
Angle, direction, period and the period strobe all share one due cycle: `max(db_len,1)+3` cycles after the pin is driven. The bench looks one cycle earlier and expects the old angle, then at that cycle expects the new values, so the latency is pinned from both sides. The quotient follows `SC_W` cycles after the period strobe. The bench therefore waits, with a bound, for `speed_vld` before comparing against the integer quotient of the last gap it drove. Timeout checks sample only after more than `tmo_lim` idle cycles have elapsed, and the ignored-event checks (short pulse, both phases together) sample after the full latency has passed.

// File: rtl/enc_pkg.sv
package enc_pkg;
  // Fractional bits of the electrical angle.
  localparam int FRAC_BITS = 8;

  // One accepted shaft step and its direction.
  typedef struct packed {
    logic valid;
    logic cw;
  } enc_step_t;
endpackage

// File: rtl/enc_debounce.sv
module enc_debounce #(
  parameter int DB_W        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            raw,
  input  logic [DB_W-1:0] db_len,
  output logic            level
);
  logic smp;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      logic [SYNC_STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[SYNC_STAGES-2:0], raw};
      end
      assign smp = chain_q[SYNC_STAGES-1];
    end else begin : g_single
      logic one_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) one_q <= 1'b0;
        else        one_q <= raw;
      end
      assign smp = one_q;
    end
  endgenerate

  logic            lvl_q, lvl_d;
  logic [DB_W-1:0] cnt_q, cnt_d;
  logic [DB_W:0]   cnt_inc;
  logic            cnt_en;

  assign cnt_inc = {1'b0, cnt_q} + {{DB_W{1'b0}}, 1'b1};

  always_comb begin
    lvl_d = lvl_q;
    cnt_d = '0;
    if (smp != lvl_q) begin
      if (cnt_inc >= {1'b0, db_len}) lvl_d = smp;
      else                           cnt_d = cnt_inc[DB_W-1:0];
    end
  end

  assign cnt_en = (cnt_d != cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign level = lvl_q;

  // R2
  lvl_from_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lvl_q) |-> (lvl_q == $past(smp)));
endmodule

// File: rtl/enc_step_decode.sv
module enc_step_decode
  import enc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      lvl_a,
  input  logic      lvl_b,
  output enc_step_t step,
  output logic      dir_cw
);
  logic prev_a_q, prev_b_q;
  logic ev_a, ev_b;
  logic dir_q, dir_d;

  assign ev_a = lvl_a ^ prev_a_q;
  assign ev_b = lvl_b ^ prev_b_q;

  always_comb begin
    step.valid = ev_a ^ ev_b;
    if (ev_a) step.cw = (lvl_a != lvl_b);
    else      step.cw = (lvl_b == lvl_a);
    dir_d = step.valid ? step.cw : dir_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_a_q <= 1'b0;
      prev_b_q <= 1'b0;
      dir_q    <= 1'b0;
    end else begin
      prev_a_q <= lvl_a;
      prev_b_q <= lvl_b;
      if (step.valid) dir_q <= dir_d;
    end
  end

  assign dir_cw = dir_q;

  // R7
  both_events_hold_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_a && ev_b) |=> $stable(dir_q));

  // R4
  dir_moves_on_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dir_q) |-> $past(ev_a != ev_b));
endmodule

// File: rtl/enc_angle_acc.sv
module enc_angle_acc
  import enc_pkg::*;
#(
  parameter int POS_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  enc_step_t        step,
  input  logic [POS_W-1:0] wrap_lim,
  output logic [POS_W-1:0] pos
);
  localparam logic [POS_W:0]   ONE_X = (POS_W+1)'(1) << FRAC_BITS;
  localparam logic [POS_W-1:0] ONE   = POS_W'(1) << FRAC_BITS;

  logic [POS_W-1:0] pos_q, pos_d;
  logic [POS_W:0]   up_sum, up_wrap, dn_diff;

  assign up_sum  = {1'b0, pos_q} + ONE_X;
  assign up_wrap = up_sum - {1'b0, wrap_lim};
  assign dn_diff = {1'b0, pos_q} - ONE_X;

  always_comb begin
    pos_d = pos_q;
    if (step.valid) begin
      if (step.cw) begin
        // No borrow means the advanced angle reached the limit.
        if (!up_wrap[POS_W]) pos_d = up_wrap[POS_W-1:0];
        else                 pos_d = up_sum[POS_W-1:0];
      end else begin
        if (dn_diff[POS_W]) pos_d = dn_diff[POS_W-1:0] + wrap_lim;
        else                pos_d = dn_diff[POS_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pos_q <= '0;
    else if (step.valid) pos_q <= pos_d;
  end

  assign pos = pos_q;

  // R5
  pos_below_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_lim >= ONE) |-> (pos_q < wrap_lim));

  // R7
  idle_pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step.valid |=> $stable(pos_q));

  // R5
  cw_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step.valid && step.cw && (up_sum < {1'b0, wrap_lim}))
      |=> (pos_q == $past(pos_q) + ONE));
endmodule

// File: rtl/enc_period_speed.sv
module enc_period_speed #(
  parameter int PER_W = 16,
  parameter int SC_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_valid,
  input  logic [PER_W-1:0] tmo_lim,
  input  logic [SC_W-1:0]  spd_scale,
  output logic [PER_W-1:0] period,
  output logic             period_vld,
  output logic [SC_W-1:0]  speed,
  output logic             speed_vld
);
  localparam int LW = $clog2(SC_W + 1);

  // Gap counter and timeout state
  logic [PER_W-1:0] cnt_q, cnt_d;
  logic             stale_q, stale_d;
  logic             at_tmo, latch, go_stale;
  logic [PER_W-1:0] per_q, per_d;
  logic             per_vld_q;

  assign at_tmo   = (cnt_q >= tmo_lim);
  assign latch    = step_valid && !stale_q && !at_tmo;
  assign go_stale = !step_valid && at_tmo && !stale_q;

  always_comb begin
    cnt_d   = cnt_q;
    stale_d = stale_q;
    per_d   = per_q;
    if (step_valid) begin
      cnt_d   = PER_W'(1);
      stale_d = 1'b0;
    end else if (!at_tmo) begin
      cnt_d = cnt_q + PER_W'(1);
    end else begin
      stale_d = 1'b1;
    end
    if (latch) per_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      stale_q   <= 1'b1;
      per_q     <= '0;
      per_vld_q <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      stale_q   <= stale_d;
      per_vld_q <= latch;
      if (latch) per_q <= per_d;
    end
  end

  // Restoring divider: one quotient bit per cycle
  logic             busy_q, busy_d;
  logic [SC_W-1:0]  dvd_q, dvd_d;
  logic [PER_W-1:0] rem_q, rem_d;
  logic [PER_W-1:0] dvs_q, dvs_d;
  logic [LW-1:0]    left_q, left_d;
  logic [SC_W-1:0]  spd_q, spd_d;
  logic             spd_vld_d, spd_vld_q;
  logic [PER_W:0]   trial, diff;
  logic             fits;
  logic [SC_W-1:0]  dvd_shift;

  assign trial     = {rem_q, dvd_q[SC_W-1]};
  assign diff      = trial - {1'b0, dvs_q};
  assign fits      = !diff[PER_W];
  assign dvd_shift = {dvd_q[SC_W-2:0], fits};

  always_comb begin
    busy_d    = busy_q;
    dvd_d     = dvd_q;
    rem_d     = rem_q;
    dvs_d     = dvs_q;
    left_d    = left_q;
    spd_d     = spd_q;
    spd_vld_d = 1'b0;
    if (go_stale) begin
      busy_d = 1'b0;
      spd_d  = '0;
    end else if (latch) begin
      busy_d = 1'b1;
      dvd_d  = spd_scale;
      rem_d  = '0;
      dvs_d  = cnt_q;
      left_d = LW'(SC_W);
    end else if (busy_q) begin
      dvd_d  = dvd_shift;
      rem_d  = fits ? diff[PER_W-1:0] : trial[PER_W-1:0];
      left_d = left_q - LW'(1);
      if (left_q == LW'(1)) begin
        busy_d    = 1'b0;
        spd_d     = dvd_shift;
        spd_vld_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      dvd_q     <= '0;
      rem_q     <= '0;
      dvs_q     <= '0;
      left_q    <= '0;
      spd_q     <= '0;
      spd_vld_q <= 1'b0;
    end else begin
      busy_q    <= busy_d;
      spd_vld_q <= spd_vld_d;
      if (busy_d || busy_q) begin
        dvd_q  <= dvd_d;
        rem_q  <= rem_d;
        dvs_q  <= dvs_d;
        left_q <= left_d;
      end
      spd_q <= spd_d;
    end
  end

  assign period     = per_q;
  assign period_vld = per_vld_q;
  assign speed      = spd_q;
  assign speed_vld  = spd_vld_q;

  // R9
  stale_speed_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stale_q |-> (spd_q == '0));

  // R8
  period_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_vld_q |-> ((per_q != '0) && (per_q < tmo_lim)));

  // R10
  quotient_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spd_vld_q |-> ($past(busy_q) && !busy_q));
endmodule

// File: rtl/enc_angle_unit.sv
module enc_angle_unit
  import enc_pkg::*;
#(
  parameter int POS_W       = 20,
  parameter int PER_W       = 16,
  parameter int SC_W        = 32,
  parameter int DB_W        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enc_a,
  input  logic             enc_b,
  input  logic [DB_W-1:0]  db_len,
  input  logic [POS_W-1:0] wrap_lim,
  input  logic [PER_W-1:0] tmo_lim,
  input  logic [SC_W-1:0]  spd_scale,
  output logic [POS_W-1:0] elec_pos,
  output logic             dir_cw,
  output logic [PER_W-1:0] period,
  output logic             period_vld,
  output logic [SC_W-1:0]  speed,
  output logic             speed_vld
);
  localparam int NCH = 2;

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  logic [NCH-1:0] raw_vec, lvl_vec;
  assign raw_vec = {enc_b, enc_a};

  generate
    for (genvar ch = 0; ch < NCH; ch++) begin : g_phase
      enc_debounce #(
        .DB_W        (DB_W),
        .SYNC_STAGES (SYNC_STAGES)
      ) u_deb (
        .clk    (clk),
        .rst_n  (rst_core_n),
        .raw    (raw_vec[ch]),
        .db_len (db_len),
        .level  (lvl_vec[ch])
      );
    end
  endgenerate

  enc_step_t step;

  enc_step_decode u_dec (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .lvl_a  (lvl_vec[0]),
    .lvl_b  (lvl_vec[1]),
    .step   (step),
    .dir_cw (dir_cw)
  );

  enc_angle_acc #(
    .POS_W (POS_W)
  ) u_ang (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .step     (step),
    .wrap_lim (wrap_lim),
    .pos      (elec_pos)
  );

  enc_period_speed #(
    .PER_W (PER_W),
    .SC_W  (SC_W)
  ) u_spd (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .step_valid (step.valid),
    .tmo_lim    (tmo_lim),
    .spd_scale  (spd_scale),
    .period     (period),
    .period_vld (period_vld),
    .speed      (speed),
    .speed_vld  (speed_vld)
  );
endmodule

// File: tb/enc_angle_unit_bench.sv
module enc_angle_unit_bench;
  logic        clk;
  logic        rst_n;
  logic        enc_a, enc_b;
  logic [7:0]  db_len;
  logic [19:0] wrap_lim;
  logic [15:0] tmo_lim;
  logic [31:0] spd_scale;
  logic [19:0] elec_pos;
  logic        dir_cw;
  logic [15:0] period;
  logic        period_vld;
  logic [31:0] speed;
  logic        speed_vld;

  enc_angle_unit u_enc_angle_unit (
    .clk        (clk),
    .rst_n      (rst_n),
    .enc_a      (enc_a),
    .enc_b      (enc_b),
    .db_len     (db_len),
    .wrap_lim   (wrap_lim),
    .tmo_lim    (tmo_lim),
    .spd_scale  (spd_scale),
    .elec_pos   (elec_pos),
    .dir_cw     (dir_cw),
    .period     (period),
    .period_vld (period_vld),
    .speed      (speed),
    .speed_vld  (speed_vld)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int  nchk = 0;
  int  nfail = 0;
  bit  finished = 0;
  int  cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Reference model state
  logic        m_a, m_b, m_dir;
  int unsigned m_pos, m_lim, m_per;
  int          m_tmo, lat, last_cyc;
  bit          have_prev;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input int lim, input int dbl);
    rst_n     = 1'b0;
    enc_a     = 1'b0;
    enc_b     = 1'b0;
    db_len    = 8'(dbl);
    wrap_lim  = 20'(lim);
    tmo_lim   = 16'd200;
    spd_scale = 32'd1000000;
    m_a = 0; m_b = 0; m_dir = 0; m_pos = 0; m_per = 0;
    m_lim = lim; m_tmo = 200; have_prev = 0;
    lat = ((dbl < 1) ? 1 : dbl) + 3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(elec_pos == 0, "R1 elec_pos", elec_pos, 0);
    chk(dir_cw == 0, "R1 dir_cw", dir_cw, 0);
    chk(period == 0, "R1 period", period, 0);
    chk(period_vld == 0, "R1 period_vld", period_vld, 0);
    chk(speed == 0, "R1 speed", speed, 0);
    chk(speed_vld == 0, "R1 speed_vld", speed_vld, 0);
  endtask

  task automatic move(input logic na, input logic nb, input int gap);
    logic        ea, eb, cw, exp_dir;
    bit          acc, latch;
    int unsigned exp_pos, exp_per;
    int          gap_now, t0;
    ea = (na != m_a);
    eb = (nb != m_b);
    acc = ea ^ eb;
    exp_pos = m_pos; exp_dir = m_dir; exp_per = m_per; latch = 0; cw = 0;
    gap_now = cyc - last_cyc;
    if (acc) begin
      cw = ea ? (na != m_b) : (nb == m_a);
      if (cw) begin
        exp_pos = m_pos + 256;
        if (exp_pos >= m_lim) exp_pos = exp_pos - m_lim;
      end else if (m_pos < 256) begin
        exp_pos = m_pos + m_lim - 256;
      end else begin
        exp_pos = m_pos - 256;
      end
      exp_dir = cw;
      latch = have_prev && (gap_now < m_tmo);
      if (latch) exp_per = gap_now;
    end
    t0 = cyc;
    enc_a = na;
    enc_b = nb;
    repeat (lat - 1) @(negedge clk);
    chk(elec_pos == m_pos, "R3 not before due cycle", elec_pos, m_pos);
    @(negedge clk);
    if (!acc)
      chk(elec_pos == exp_pos, "R7 position kept", elec_pos, exp_pos);
    else if (cw)
      chk(elec_pos == exp_pos, "R5 clockwise step", elec_pos, exp_pos);
    else
      chk(elec_pos == exp_pos, "R6 counter-clockwise step", elec_pos, exp_pos);
    chk(dir_cw == exp_dir, "R4 direction", dir_cw, exp_dir);
    chk(period_vld == latch, latch ? "R8 period strobe" : "R9 no period strobe",
        period_vld, latch);
    chk(period == exp_per, "R8 period value", period, exp_per);
    m_a = na; m_b = nb; m_pos = exp_pos; m_dir = exp_dir; m_per = exp_per;
    if (acc) begin
      last_cyc = t0;
      have_prev = 1;
    end
    if (gap > lat) repeat (gap - lat) @(negedge clk);
  endtask

  task automatic step_cw(input int gap);
    if (m_a == m_b) move(~m_a, m_b, gap);
    else            move(m_a, ~m_b, gap);
  endtask

  task automatic step_ccw(input int gap);
    if (m_a == m_b) move(m_a, ~m_b, gap);
    else            move(~m_a, m_b, gap);
  endtask

  task automatic wait_speed(input int unsigned exp_spd);
    bit seen;
    seen = 0;
    for (int i = 0; i < 80; i++) begin
      if (speed_vld) begin
        seen = 1;
        break;
      end
      @(negedge clk);
    end
    chk(seen, "R10 speed strobe", seen, 1);
    chk(speed == exp_spd, "R10 speed quotient", speed, exp_spd);
  endtask

  task automatic glitch_a(input int width);
    int unsigned p0;
    logic        d0;
    p0 = m_pos; d0 = m_dir;
    enc_a = ~m_a;
    repeat (width) @(negedge clk);
    enc_a = m_a;
    repeat (lat + 4) @(negedge clk);
    chk(elec_pos == p0, "R2 short pulse position", elec_pos, p0);
    chk(dir_cw == d0, "R2 short pulse direction", dir_cw, d0);
    chk(period == m_per, "R2 short pulse period", period, m_per);
  endtask

  initial begin
    last_cyc = 0;
    // Fractional limit 5.5 steps, two-sample filter
    do_reset(1408, 2);
    for (int i = 0; i < 24; i++) step_cw(10);
    wait_speed(1000000 / 10);
    for (int i = 0; i < 7; i++) step_cw(37);
    wait_speed(1000000 / 37);
    repeat (230) @(negedge clk);
    chk(speed == 0, "R9 speed after timeout", speed, 0);
    for (int i = 0; i < 30; i++) step_ccw(12);
    wait_speed(1000000 / 12);
    glitch_a(1);
    move(~m_a, ~m_b, 20);
    chk(period_vld == 0, "R7 no strobe later", period_vld, 0);
    for (int i = 0; i < 6; i++) step_cw(15);
    for (int i = 0; i < 6; i++) step_ccw(15);
    // Gap equal to the timeout: restart only
    step_cw(200);
    step_cw(9);
    // Limit 3.25 steps, filter length 0 acts as 1
    do_reset(832, 0);
    for (int i = 0; i < 20; i++) step_cw(9);
    wait_speed(1000000 / 9);
    for (int i = 0; i < 9; i++) step_ccw(9);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule